// File: doc/BRIEF.md
# DMA Request Sync Gate

This block is one channel of a DMA request router. A peripheral request that has already been selected arrives on `req_in`. The block passes it on to a DMA channel on `req_out`. An external synchronization line can gate the request. When gating is enabled, the channel stays closed until an active edge appears on the chosen sync line. It then opens a window that forwards requests until the DMA has served a programmed number of them, and closes again.

The sync source comes from a 32-entry line space, addressed by a 5-bit select. Lines 0 to 15 carry the GPIO interrupt lines. Lines 16 to 22 carry request-generator events 1 to 7. Lines 23 to 31 are tied inactive. The chosen line passes through a two-flop synchronizer and an edge detector before it reaches the gating state machine. The state machine has three states. `ST_PASS` forwards requests with no gating. `ST_HOLD` blocks requests while it waits for a sync edge. `ST_OPEN` forwards requests while the burst counter runs.

The transitions are as follows. Any state goes to `ST_PASS` when gating is disabled. `ST_PASS` goes to `ST_HOLD` once gating is enabled. `ST_HOLD` goes to `ST_OPEN` on an active edge. `ST_OPEN` goes to `ST_HOLD` when the DMA serves the request that takes the counter through zero. A sync edge that arrives inside an open window sets a sticky overflow flag, which can raise an interrupt. An APB-style register port holds the control word, the status flag and a write-one clear.

Top module: `dma_sync_gate`

## Requirements
- R1: Sync select values 0..15 pick `gpio_line[sel]`, values 16..22 pick `gen_evt[sel-16]`, and values 23..31 give a constant inactive line that never opens a window.
- R2: When control bit 0 (gating enable) is 0, `req_out` equals `req_in`. Once the bit has been 0 for one full cycle, the state is `ST_PASS`.
- R3: Control bits [2:1] choose the active edge: 00 none, 01 rising, 10 falling, 11 both. The line goes through two synchronizing flops and one history flop. A level change that is applied before clock edge k opens the window after edge k+2.
- R4: In `ST_HOLD`, `req_out` is 0 whatever `req_in` does.
- R5: In `ST_OPEN`, `req_out` follows `req_in`. The counter loads from control bits [23:16] (N) and drops by one on each cycle with `req_served` high. The serve that finds the counter at 0 closes the window, so N+1 serves pass per window.
- R6: When control bit 3 is 1, `evt_out` is high for exactly the one cycle after the closing serve. Otherwise it stays 0.
- R7: An active edge while in `ST_OPEN` sets the overflow flag (status register bit 0). The count continues from its present value. The flag stays set until it is cleared.
- R8: A write to the clear register at offset 0x8 with bit 0 set clears the flag. Writing 0 there has no effect. A flag set in the same cycle wins over the clear.
- R9: `irq` is high exactly while the overflow flag is 1 and control bit 4 is 1.
- R10: After reset, the control register (offset 0x0) and status register (offset 0x4) read 0 and the channel is in `ST_PASS`. Control bits [12:8] hold the sync select. The clear register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_line | input | 16 | GPIO interrupt lines, sync sources 0..15 |
| gen_evt | input | 7 | Request-generator events, sync sources 16..22 |
| req_in | input | 1 | Selected peripheral request |
| req_served | input | 1 | DMA has served the forwarded request this cycle |
| req_out | output | 1 | Request to the DMA channel |
| evt_out | output | 1 | One-cycle pulse at the end of a burst |
| irq | output | 1 | Overflow interrupt |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | Register port write |
| paddr | input | 4 | Register byte offset |
| pwdata | input | 32 | Register write data |
| prdata | output | 32 | Register read data |

## Verification
The hardest case to reach is an overflow. It needs a second active edge that lands while a window is still open. That edge has to get through three flops of sync latency, and the DMA must not finish the burst first. The bench drives `req_served` low and opens a window with one edge. After the pipeline delay it sends a second edge, and only then restarts serving to show that the count carries on. Edges that fall on the same cycle as the closing serve, and clears that meet a new overflow, come from long stretches of random serving mixed with sync toggles. A behavioural model checks every one of those cycles.

// File: rtl/dma_sync_pkg.sv
package dma_sync_pkg;

    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_HOLD = 2'd1,
        ST_OPEN = 2'd2
    } gate_state_t;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_t;

    localparam logic [3:0] ADDR_CTRL = 4'h0;
    localparam logic [3:0] ADDR_STAT = 4'h4;
    localparam logic [3:0] ADDR_CLR  = 4'h8;

    localparam int CTRL_SEL_LSB = 8;
    localparam int CTRL_CNT_LSB = 16;

endpackage

// File: rtl/dma_sync_edge.sv
module dma_sync_edge
    import dma_sync_pkg::*;
#(
    parameter int GPIO_N = 16,
    parameter int GEN_N  = 7,
    parameter int SEL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GPIO_N-1:0] gpio_line,
    input  logic [GEN_N-1:0]  gen_evt,
    input  logic [SEL_W-1:0]  src_sel,
    input  edge_mode_t        edge_mode,
    output logic              edge_pulse
);
    localparam int LINES = 2 ** SEL_W;

    logic [LINES-1:0] line_vec;
    logic             line_pick;
    logic             sync_a, sync_b, hist;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        if (i < GPIO_N) begin : g_gpio
            assign line_vec[i] = gpio_line[i];
        end else if (i < GPIO_N + GEN_N) begin : g_gen
            assign line_vec[i] = gen_evt[i-GPIO_N];
        end else begin : g_tie
            assign line_vec[i] = 1'b0;
        end
    end

    assign line_pick = line_vec[src_sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
            hist   <= 1'b0;
        end else begin
            sync_a <= line_pick;
            sync_b <= sync_a;
            hist   <= sync_b;
        end
    end

    always_comb begin
        unique case (edge_mode)
            EDGE_RISE: edge_pulse = sync_b & ~hist;
            EDGE_FALL: edge_pulse = ~sync_b & hist;
            EDGE_BOTH: edge_pulse = sync_b ^ hist;
            default:   edge_pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma_sync_regs.sv
module dma_sync_regs
    import dma_sync_pkg::*;
#(
    parameter int SEL_W = 5,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [3:0]       paddr,
    input  logic [31:0]      pwdata,
    output logic [31:0]      prdata,
    input  logic             ovf_set,
    output logic             gate_en,
    output edge_mode_t       edge_mode,
    output logic             evt_en,
    output logic             ovf_ie,
    output logic [SEL_W-1:0] src_sel,
    output logic [CNT_W-1:0] burst_len,
    output logic             ovf_flag,
    output logic             irq
);
    logic wr_stb;
    logic clr_stb;

    assign wr_stb  = psel & penable & pwrite;
    assign clr_stb = wr_stb & (paddr == ADDR_CLR) & pwdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_en   <= 1'b0;
            edge_mode <= EDGE_NONE;
            evt_en    <= 1'b0;
            ovf_ie    <= 1'b0;
            src_sel   <= '0;
            burst_len <= '0;
        end else if (wr_stb && paddr == ADDR_CTRL) begin
            gate_en   <= pwdata[0];
            edge_mode <= edge_mode_t'(pwdata[2:1]);
            evt_en    <= pwdata[3];
            ovf_ie    <= pwdata[4];
            src_sel   <= pwdata[CTRL_SEL_LSB +: SEL_W];
            burst_len <= pwdata[CTRL_CNT_LSB +: CNT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (ovf_set) begin
            ovf_flag <= 1'b1;
        end else if (clr_stb) begin
            ovf_flag <= 1'b0;
        end
    end

    assign irq = ovf_flag & ovf_ie;

    always_comb begin
        prdata = '0;
        unique case (paddr)
            ADDR_CTRL: begin
                prdata[0]                      = gate_en;
                prdata[2:1]                    = edge_mode;
                prdata[3]                      = evt_en;
                prdata[4]                      = ovf_ie;
                prdata[CTRL_SEL_LSB +: SEL_W]  = src_sel;
                prdata[CTRL_CNT_LSB +: CNT_W]  = burst_len;
            end
            ADDR_STAT: prdata[0] = ovf_flag;
            default:   prdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_sync_fsm.sv
module dma_sync_fsm
    import dma_sync_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_en,
    input  logic             evt_en,
    input  logic [CNT_W-1:0] burst_len,
    input  logic             edge_pulse,
    input  logic             req_in,
    input  logic             req_served,
    output logic             req_out,
    output logic             evt_out,
    output logic             ovf_set,
    output gate_state_t      state
);
    gate_state_t      state_nxt;
    logic [CNT_W-1:0] cnt;
    logic             last_serve;

    assign last_serve = (state == ST_OPEN) && req_served && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_PASS;
            cnt     <= '0;
            evt_out <= 1'b0;
        end else begin
            state   <= state_nxt;
            evt_out <= gate_en && evt_en && last_serve;
            if (!gate_en || state != ST_OPEN) begin
                cnt <= burst_len;
            end else if (req_served) begin
                cnt <= (cnt == '0) ? burst_len : cnt - 1'b1;
            end
        end
    end

    always_comb begin
        state_nxt = state;
        if (!gate_en) begin
            state_nxt = ST_PASS;
        end else begin
            unique case (state)
                ST_PASS: state_nxt = ST_HOLD;
                ST_HOLD: if (edge_pulse) state_nxt = ST_OPEN;
                ST_OPEN: if (last_serve) state_nxt = ST_HOLD;
                default: state_nxt = ST_PASS;
            endcase
        end
    end

    always_comb begin
        req_out = 1'b0;
        ovf_set = 1'b0;
        unique case (state)
            ST_PASS: req_out = req_in;
            ST_OPEN: begin
                req_out = req_in;
                ovf_set = gate_en && edge_pulse;
            end
            default: req_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma_sync_gate.sv
module dma_sync_gate
    import dma_sync_pkg::*;
#(
    parameter int GPIO_N = 16,
    parameter int GEN_N  = 7,
    parameter int SEL_W  = 5,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GPIO_N-1:0] gpio_line,
    input  logic [GEN_N-1:0]  gen_evt,
    input  logic              req_in,
    input  logic              req_served,
    output logic              req_out,
    output logic              evt_out,
    output logic              irq,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [3:0]        paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata
);
    logic             gate_en;
    edge_mode_t       edge_mode;
    logic             evt_en;
    logic             ovf_ie;
    logic [SEL_W-1:0] src_sel;
    logic [CNT_W-1:0] burst_len;
    logic             ovf_flag;
    logic             ovf_set;
    logic             edge_pulse;
    gate_state_t      state;

    dma_sync_regs #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .ovf_set(ovf_set),
        .gate_en(gate_en), .edge_mode(edge_mode), .evt_en(evt_en),
        .ovf_ie(ovf_ie), .src_sel(src_sel), .burst_len(burst_len),
        .ovf_flag(ovf_flag), .irq(irq)
    );

    dma_sync_edge #(.GPIO_N(GPIO_N), .GEN_N(GEN_N), .SEL_W(SEL_W)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .gpio_line(gpio_line), .gen_evt(gen_evt),
        .src_sel(src_sel), .edge_mode(edge_mode),
        .edge_pulse(edge_pulse)
    );

    dma_sync_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .gate_en(gate_en), .evt_en(evt_en), .burst_len(burst_len),
        .edge_pulse(edge_pulse),
        .req_in(req_in), .req_served(req_served),
        .req_out(req_out), .evt_out(evt_out),
        .ovf_set(ovf_set), .state(state)
    );

endmodule

// File: rtl/dma_sync_gate_chk.sv
module dma_sync_gate_chk
    import dma_sync_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        gate_en,
    input logic        req_in,
    input logic        req_out,
    input logic        evt_out,
    input logic        irq,
    input logic        ovf_flag,
    input logic        edge_pulse,
    input gate_state_t state,
    input logic        psel,
    input logic        penable,
    input logic        pwrite,
    input logic [3:0]  paddr,
    input logic [31:0] pwdata
);
    logic clr_hit;
    logic open_edge;

    assign clr_hit   = psel && penable && pwrite && (paddr == ADDR_CLR) && pwdata[0];
    assign open_edge = gate_en && (state == ST_OPEN) && edge_pulse;

    assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en && $past(!gate_en)) |-> (req_out == req_in));

    assert_evt_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_out |=> !evt_out);

    assert_closed_after_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_out |-> !req_out);

    assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        open_edge |=> ovf_flag);

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_hit) |=> ovf_flag);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !open_edge) |=> (!ovf_flag && !irq));

endmodule

bind dma_sync_gate dma_sync_gate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en),
    .req_in(req_in), .req_out(req_out), .evt_out(evt_out), .irq(irq),
    .ovf_flag(ovf_flag), .edge_pulse(edge_pulse), .state(state),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata)
);

// File: tb/sim_dma_sync_gate.sv
`timescale 1ns/1ps
module sim_dma_sync_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] gpio_line = '0;
    logic [6:0]  gen_evt = '0;
    logic        req_in = 1'b0;
    logic        req_served = 1'b0;
    logic        req_out, evt_out, irq;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [3:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;

    int    checks = 0;
    int    errors = 0;
    bit    rnd_on = 1'b0;
    bit    done = 1'b0;
    string tag = "R10";

    always #2 clk = ~clk;

    dma_sync_gate u0 (
        .clk(clk), .rst_n(rst_n), .gpio_line(gpio_line), .gen_evt(gen_evt),
        .req_in(req_in), .req_served(req_served),
        .req_out(req_out), .evt_out(evt_out), .irq(irq),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata)
    );

    // behavioural reference model: 0 = passing, 1 = waiting, 2 = window open
    int mst, mcnt;
    bit s1, s2, s3, movf, mevt;
    bit m_en, m_evten, m_ie;
    int m_mode, m_sel, m_len;

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; mcnt = 0; s1 = 0; s2 = 0; s3 = 0; movf = 0; mevt = 0;
            m_en = 0; m_evten = 0; m_ie = 0; m_mode = 0; m_sel = 0; m_len = 0;
        end else begin
            bit line, edg, nevt, novf;
            int nst, ncnt;
            if (m_sel < 16) line = gpio_line[m_sel];
            else if (m_sel < 23) line = gen_evt[m_sel-16];
            else line = 0;
            case (m_mode)
                1: edg = s2 && !s3;
                2: edg = !s2 && s3;
                3: edg = s2 != s3;
                default: edg = 0;
            endcase
            nst = mst; ncnt = mcnt; nevt = 0; novf = movf;
            if (psel && penable && pwrite && paddr == 4'h8 && pwdata[0]) novf = 0;
            if (!m_en) begin
                nst = 0; ncnt = m_len;
            end else if (mst == 0) begin
                nst = 1; ncnt = m_len;
            end else if (mst == 1) begin
                ncnt = m_len;
                if (edg) nst = 2;
            end else begin
                if (edg) novf = 1;
                if (req_served) begin
                    if (mcnt == 0) begin
                        nst = 1; ncnt = m_len; nevt = m_evten;
                    end else ncnt = mcnt - 1;
                end
            end
            if (psel && penable && pwrite && paddr == 4'h0) begin
                m_en = pwdata[0]; m_mode = int'(pwdata[2:1]); m_evten = pwdata[3];
                m_ie = pwdata[4]; m_sel = int'(pwdata[12:8]); m_len = int'(pwdata[23:16]);
            end
            s3 = s2; s2 = s1; s1 = line;
            mst = nst; mcnt = ncnt; mevt = nevt; movf = novf;
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic [31:0] rexp;
            check({31'b0, req_out}, {31'b0, req_in && (mst != 1)}, "req_out (R2 R4 R5)");
            check({31'b0, evt_out}, {31'b0, mevt}, "evt_out (R6)");
            check({31'b0, irq}, {31'b0, movf && m_ie}, "irq (R7 R9)");
            if (psel && penable && !pwrite) begin
                rexp = '0;
                if (paddr == 4'h0)
                    rexp = {8'b0, 8'(m_len), 3'b0, 5'(m_sel), 3'b0, m_ie, m_evten, 2'(m_mode), m_en};
                else if (paddr == 4'h4)
                    rexp = {31'b0, movf};
                check(prdata, rexp, "prdata (R8 R10)");
            end
        end
    end

    task automatic step();
        @(negedge clk);
        if (rnd_on) begin
            req_in     = 1'($urandom % 2);
            req_served = 1'($urandom % 2);
        end
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic apb_wr(input logic [3:0] a, input logic [31:0] d);
        step(); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        step(); penable = 1;
        step(); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [3:0] a);
        step(); psel = 1; pwrite = 0; paddr = a; penable = 0;
        step(); penable = 1;
        step(); psel = 0; penable = 0;
    endtask

    function automatic logic [31:0] mkctrl(input bit en, input int mode, input bit ev,
                                          input bit ie, input int sel, input int len);
        return {8'b0, 8'(len), 3'b0, 5'(sel), 3'b0, ie, ev, 2'(mode), en};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset values
        tag = "R10";
        apb_rd(4'h0); apb_rd(4'h4); apb_rd(4'h8);
        // R2: pass-through with gating disabled
        tag = "R2"; rnd_on = 1; steps(20);
        // R4: enabled but no sync edge
        tag = "R4";
        apb_wr(4'h0, mkctrl(1, 1, 1, 1, 3, 2));
        apb_rd(4'h0);
        steps(12);
        // R5 R6: bursts on rising edges of gpio 3
        tag = "R5 R6";
        gpio_line[3] = 1; steps(40);
        gpio_line[3] = 0; steps(6);
        gpio_line[3] = 1; steps(40);
        gpio_line[3] = 0; steps(6);
        apb_wr(4'h0, mkctrl(1, 1, 1, 1, 3, 0));
        gpio_line[3] = 1; steps(20); gpio_line[3] = 0; steps(6);
        // R7 R9: edge inside an open window, serving held off
        tag = "R7 R9";
        apb_wr(4'h0, mkctrl(1, 1, 1, 1, 3, 3));
        rnd_on = 0; req_in = 1; req_served = 0;
        gpio_line[3] = 1; steps(6);
        gpio_line[3] = 0; steps(4);
        gpio_line[3] = 1; steps(6);
        gpio_line[3] = 0;
        rnd_on = 1; steps(30);
        // R8: clear behaviour
        tag = "R8";
        apb_rd(4'h4);
        apb_wr(4'h8, 32'h0); apb_rd(4'h4);
        apb_wr(4'h8, 32'h1); apb_rd(4'h4);
        // R9: overflow with interrupt disabled
        tag = "R9";
        apb_wr(4'h0, mkctrl(1, 1, 0, 0, 3, 4));
        rnd_on = 0; req_in = 1; req_served = 0;
        gpio_line[3] = 1; steps(6); gpio_line[3] = 0; steps(4);
        gpio_line[3] = 1; steps(6); gpio_line[3] = 0;
        apb_rd(4'h4);
        apb_wr(4'h0, mkctrl(1, 1, 0, 1, 3, 4)); steps(3);
        apb_wr(4'h8, 32'h1);
        rnd_on = 1; steps(20);
        // R3: falling, both and no-edge modes on generator event 3 (select 18)
        tag = "R3";
        apb_wr(4'h0, mkctrl(1, 2, 1, 1, 18, 1));
        gen_evt[2] = 1; steps(10); gen_evt[2] = 0; steps(25);
        apb_wr(4'h0, mkctrl(1, 3, 1, 1, 18, 1));
        gen_evt[2] = 1; steps(25); gen_evt[2] = 0; steps(25);
        apb_wr(4'h0, mkctrl(1, 0, 1, 1, 18, 1));
        steps(8);
        gen_evt[2] = 1; steps(10); gen_evt[2] = 0; steps(10);
        // R1: reserved select stays inactive, select 16 uses generator event 1
        tag = "R1";
        apb_wr(4'h0, mkctrl(1, 3, 1, 1, 25, 1));
        gpio_line = '1; gen_evt = '1; steps(10);
        gpio_line = '0; gen_evt = '0; steps(10);
        apb_wr(4'h0, mkctrl(1, 1, 1, 1, 16, 2));
        gpio_line = '1; steps(10); gpio_line = '0;
        gen_evt[0] = 1; steps(30); gen_evt[0] = 0; steps(5);
        // R2: gating switched off mid-window
        tag = "R2";
        gen_evt[0] = 1; rnd_on = 0; req_in = 1; req_served = 0; steps(6);
        apb_wr(4'h0, mkctrl(0, 1, 1, 1, 16, 2));
        rnd_on = 1; steps(20);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule